// File: doc/BRIEF.md
# Shared Work-RAM Bank Mapper

Two CPUs share a work RAM built from two equal halves. A 2-bit mode register decides which halves each CPU reaches through its window. The window spans two halves and repeats across the CPU's whole shared-RAM address region. Both CPU request ports are decoded every cycle. Each request is steered to half 0, to half 1, to the second CPU's private RAM, or to nothing. The two CPUs always get complementary views of the storage.

In the full-size configuration each half holds 16 KB (`HALF_WORDS` = 4096 words of 32 bits). The default is smaller so that elaboration stays light. The private RAM is as large as one window.

Mode values and what each CPU sees:

| Mode | First CPU | Second CPU |
|------|-----------|------------|
| 0 | both halves, in address order | its private RAM |
| 1 | half 1, mirrored | half 0, mirrored |
| 2 | half 0, mirrored | half 1, mirrored |
| 3 | nothing | both halves, in address order |

In mode 3 the first CPU is unmapped: its writes are dropped and its reads return zero. Accesses are 32 bits wide with byte enables. Read data arrives one cycle after the request is accepted.

Top module: `wram_map`

## Requirements
- R1: The mode register resets to 0. It loads `cfg_wdata_i[25:24]` on a clock edge where `cfg_we_i` is high and `cfg_be_i[3]` is high, and is unchanged otherwise. `stat_o[9:8]` shows the current mode and every other `stat_o` bit is 0.
- R2: In mode 0, the first CPU's window offset bit `HAW` selects the half: 0 selects half 0 and 1 selects half 1. The second CPU's window reaches its private RAM through the whole window offset.
- R3: In mode 1 the first CPU reaches half 1 from both halves of its window, and the second CPU reaches half 0 from both halves of its window.
- R4: In mode 2 the first CPU reaches half 0 from both halves of its window, and the second CPU reaches half 1 from both halves of its window.
- R5: In mode 3 the second CPU reaches both halves, with window offset bit `HAW` selecting the half. A first-CPU write changes no storage, and a first-CPU read returns 0 with `a_rvalid_o` high.
- R6: Only the low `HAW+1` word-address bits select the location. Addresses that differ only in higher bits reach the same word.
- R7: A read accepted in cycle t raises `x_rvalid_o` with the data in cycle t+1. Writes raise no `x_rvalid_o`. A write updates only the bytes whose `be` bit is set, and byte k is data bits [8k+7:8k].
- R8: The first CPU is never stalled (`a_gnt_o` equals `a_req_i`). The second CPU is refused (`b_gnt_o` low) only when both CPUs target the same half in the same cycle. Because the four maps are complementary, this means `b_gnt_o` equals `b_req_i` in every mode.
- R9: The halves are shared storage. Data written by one CPU under one mode is read back by the other CPU under a mode that maps the same half. Private RAM contents persist across mode changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe (first CPU) |
| cfg_be_i | input | DW/8 | Control word byte enables |
| cfg_wdata_i | input | DW | Control word data; mode in [25:24] |
| stat_o | output | DW | Status word for second CPU; mode in [9:8] |
| a_req_i | input | 1 | First CPU request |
| a_we_i | input | 1 | First CPU write |
| a_addr_i | input | AW | First CPU word address in region |
| a_be_i | input | DW/8 | First CPU byte enables |
| a_wdata_i | input | DW | First CPU write data |
| a_gnt_o | output | 1 | First CPU request accepted |
| a_rvalid_o | output | 1 | First CPU read data valid |
| a_rdata_o | output | DW | First CPU read data |
| b_req_i | input | 1 | Second CPU request |
| b_we_i | input | 1 | Second CPU write |
| b_addr_i | input | AW | Second CPU word address in region |
| b_be_i | input | DW/8 | Second CPU byte enables |
| b_wdata_i | input | DW | Second CPU write data |
| b_gnt_o | output | 1 | Second CPU request accepted |
| b_rvalid_o | output | 1 | Second CPU read data valid |
| b_rdata_o | output | DW | Second CPU read data |

## Verification
A mode write can land in the same cycle as accesses from both CPUs. Those accesses must be routed under the old mode, including a read whose data returns one cycle later, after the new mode is already visible. The bench provokes this by issuing a mode change together with reads and writes from both ports. It also does this many times during a long random phase. A behavioural reference updates its mode only after it has routed that cycle's accesses, and the outputs are compared against it on every clock. The same-half contention case is judged by checking on every cycle that the second CPU is never refused under any mode.

// File: rtl/wram_map_pkg.sv
package wram_map_pkg;
  typedef enum logic [1:0] {
    TGT_H0   = 2'd0,
    TGT_H1   = 2'd1,
    TGT_PRIV = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    MODE_A_ALL = 2'd0,
    MODE_A_HI  = 2'd1,
    MODE_A_LO  = 2'd2,
    MODE_B_ALL = 2'd3
  } mode_e;

  localparam int MODE_LSB = 24;  // mode field in control word byte 3
  localparam int STAT_LSB = 8;   // mode field in status word
endpackage

// File: rtl/wram_route.sv
module wram_route
  import wram_map_pkg::*;
#(
  parameter bit SECOND = 1'b0
) (
  input  mode_e mode_i,
  input  logic  hi_i,
  output tgt_e  tgt_o
);
  generate
    if (!SECOND) begin : g_first
      always_comb begin
        unique case (mode_i)
          MODE_A_ALL: tgt_o = hi_i ? TGT_H1 : TGT_H0;
          MODE_A_HI:  tgt_o = TGT_H1;
          MODE_A_LO:  tgt_o = TGT_H0;
          default:    tgt_o = TGT_NONE;
        endcase
      end
    end else begin : g_second
      always_comb begin
        unique case (mode_i)
          MODE_A_ALL: tgt_o = TGT_PRIV;
          MODE_A_HI:  tgt_o = TGT_H0;
          MODE_A_LO:  tgt_o = TGT_H1;
          default:    tgt_o = hi_i ? TGT_H1 : TGT_H0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/wram_bank.sv
module wram_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int NB   = DW / 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      rdata_o <= mem[idx_i];
      if (we_i) begin
        for (int k = 0; k < NB; k++) begin
          if (be_i[k]) mem[idx_i][8*k +: 8] <= wdata_i[8*k +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/wram_map.sv
module wram_map
  import wram_map_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 12,
  parameter int HALF_WORDS = 256,
  localparam int NB        = DW / 8,
  localparam int HAW       = $clog2(HALF_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [NB-1:0] cfg_be_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [DW-1:0] stat_o,
  input  logic          a_req_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [NB-1:0] a_be_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic          a_gnt_o,
  output logic          a_rvalid_o,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_req_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [NB-1:0] b_be_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic          b_gnt_o,
  output logic          b_rvalid_o,
  output logic [DW-1:0] b_rdata_o
);
  localparam int MBYTE = MODE_LSB / 8;

  mode_e mode_q;
  tgt_e  a_tgt, b_tgt, a_src_q, b_src_q;
  logic  a_rv_q, b_rv_q;
  logic [1:0] a_claim, b_want;
  logic  b_stall;
  logic [DW-1:0] h_rdata [2];
  logic [DW-1:0] p_rdata;

  logic unused_bits;
  assign unused_bits = ^{a_addr_i[AW-1:HAW+1], b_addr_i[AW-1:HAW+1],
                         cfg_wdata_i[DW-1:MODE_LSB+2], cfg_wdata_i[MODE_LSB-1:0],
                         cfg_be_i[MBYTE-1:0]};

  // mode register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             mode_q <= MODE_A_ALL;
    else if (cfg_we_i && cfg_be_i[MBYTE])    mode_q <= mode_e'(cfg_wdata_i[MODE_LSB +: 2]);
  end

  always_comb begin
    stat_o = '0;
    stat_o[STAT_LSB +: 2] = mode_q;
  end

  wram_route #(.SECOND(1'b0)) u_route_a (.mode_i(mode_q), .hi_i(a_addr_i[HAW]), .tgt_o(a_tgt));
  wram_route #(.SECOND(1'b1)) u_route_b (.mode_i(mode_q), .hi_i(b_addr_i[HAW]), .tgt_o(b_tgt));

  // first CPU has priority on a contended half
  assign b_stall = |(a_claim & b_want);
  assign a_gnt_o = a_req_i;
  assign b_gnt_o = b_req_i && !b_stall;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_half
      localparam tgt_e HT = (k == 0) ? TGT_H0 : TGT_H1;
      logic          use_b;
      logic          en, we;
      logic [NB-1:0] be;
      logic [HAW-1:0] idx;
      logic [DW-1:0] wd;

      assign a_claim[k] = a_req_i && (a_tgt == HT);
      assign b_want[k]  = b_req_i && (b_tgt == HT);
      assign use_b      = b_want[k] && !a_claim[k];

      always_comb begin
        en  = a_claim[k] || use_b;
        we  = a_claim[k] ? a_we_i    : b_we_i;
        be  = a_claim[k] ? a_be_i    : b_be_i;
        idx = a_claim[k] ? a_addr_i[HAW-1:0] : b_addr_i[HAW-1:0];
        wd  = a_claim[k] ? a_wdata_i : b_wdata_i;
      end

      wram_bank #(.DW(DW), .DEPTH(HALF_WORDS)) u_half (
        .clk_i(clk_i), .en_i(en), .we_i(we), .be_i(be),
        .idx_i(idx), .wdata_i(wd), .rdata_o(h_rdata[k])
      );
    end
  endgenerate

  logic p_en;
  assign p_en = b_req_i && (b_tgt == TGT_PRIV);

  wram_bank #(.DW(DW), .DEPTH(2 * HALF_WORDS)) u_priv (
    .clk_i(clk_i), .en_i(p_en), .we_i(b_we_i), .be_i(b_be_i),
    .idx_i(b_addr_i[HAW:0]), .wdata_i(b_wdata_i), .rdata_o(p_rdata)
  );

  // return path: remember where each read went
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rv_q  <= 1'b0;
      b_rv_q  <= 1'b0;
      a_src_q <= TGT_NONE;
      b_src_q <= TGT_NONE;
    end else begin
      a_rv_q  <= a_req_i && !a_we_i;
      b_rv_q  <= b_gnt_o && !b_we_i;
      a_src_q <= a_tgt;
      b_src_q <= b_tgt;
    end
  end

  function automatic logic [DW-1:0] pick(tgt_e src, logic [DW-1:0] d0,
                                         logic [DW-1:0] d1, logic [DW-1:0] dp);
    unique case (src)
      TGT_H0:   return d0;
      TGT_H1:   return d1;
      TGT_PRIV: return dp;
      default:  return '0;
    endcase
  endfunction

  assign a_rvalid_o = a_rv_q;
  assign b_rvalid_o = b_rv_q;
  assign a_rdata_o  = a_rv_q ? pick(a_src_q, h_rdata[0], h_rdata[1], '0) : '0;
  assign b_rdata_o  = b_rv_q ? pick(b_src_q, h_rdata[0], h_rdata[1], p_rdata) : '0;
endmodule

// File: rtl/wram_map_chk.sv
module wram_map_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_wr_i,
  input logic [1:0]    mode_val_i,
  input logic [DW-1:0] stat_o,
  input logic          a_req_i,
  input logic          a_we_i,
  input logic          a_gnt_o,
  input logic          a_rvalid_o,
  input logic [DW-1:0] a_rdata_o,
  input logic          b_req_i,
  input logic          b_we_i,
  input logic          b_gnt_o,
  input logic          b_rvalid_o
);
  assert_mode_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (stat_o[9:8] == $past(mode_val_i)));

  assert_mode_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr_i |=> $stable(stat_o));

  assert_unmapped_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[9:8] == 2'd3 && a_req_i && !a_we_i) |=> (a_rvalid_o && a_rdata_o == '0));

  assert_a_rd_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_req_i && !a_we_i) |=> a_rvalid_o);

  assert_a_no_stray_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_req_i && !a_we_i) |=> !a_rvalid_o);

  assert_b_rd_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_gnt_o && !b_we_i) |=> b_rvalid_o);

  assert_b_no_stray_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(b_gnt_o && !b_we_i) |=> !b_rvalid_o);

  assert_a_never_waits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_req_i |-> a_gnt_o);

  assert_b_free_when_a_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_req_i |-> (b_gnt_o == b_req_i));
endmodule

bind wram_map wram_map_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mode_wr_i(cfg_we_i && cfg_be_i[3]), .mode_val_i(cfg_wdata_i[25:24]),
  .stat_o(stat_o),
  .a_req_i(a_req_i), .a_we_i(a_we_i), .a_gnt_o(a_gnt_o),
  .a_rvalid_o(a_rvalid_o), .a_rdata_o(a_rdata_o),
  .b_req_i(b_req_i), .b_we_i(b_we_i), .b_gnt_o(b_gnt_o), .b_rvalid_o(b_rvalid_o)
);

// File: tb/sim_wram_map.sv
`timescale 1ns/1ps
module sim_wram_map;
  localparam int DW   = 32;
  localparam int AW   = 12;
  localparam int HALF = 256;
  localparam int WIN  = 2 * HALF;
  localparam int NB   = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cfg_we;
  logic [NB-1:0] cfg_be;
  logic [DW-1:0] cfg_wdata;
  logic [DW-1:0] stat;
  logic          a_req, a_we, a_gnt, a_rvalid;
  logic [AW-1:0] a_addr;
  logic [NB-1:0] a_be;
  logic [DW-1:0] a_wdata, a_rdata;
  logic          b_req, b_we, b_gnt, b_rvalid;
  logic [AW-1:0] b_addr;
  logic [NB-1:0] b_be;
  logic [DW-1:0] b_wdata, b_rdata;

  wram_map #(.DW(DW), .AW(AW), .HALF_WORDS(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .stat_o(stat),
    .a_req_i(a_req), .a_we_i(a_we), .a_addr_i(a_addr), .a_be_i(a_be), .a_wdata_i(a_wdata),
    .a_gnt_o(a_gnt), .a_rvalid_o(a_rvalid), .a_rdata_o(a_rdata),
    .b_req_i(b_req), .b_we_i(b_we), .b_addr_i(b_addr), .b_be_i(b_be), .b_wdata_i(b_wdata),
    .b_gnt_o(b_gnt), .b_rvalid_o(b_rvalid), .b_rdata_o(b_rdata)
  );

  // reference model state; targets: 0 half0, 1 half1, 2 private, 3 none
  int            mode_m;
  logic [DW-1:0] h0_m [HALF];
  logic [DW-1:0] h1_m [HALF];
  logic [DW-1:0] pv_m [WIN];
  logic          exp_arv, exp_brv;
  logic [DW-1:0] exp_ard, exp_brd;
  int            n_chk, n_fail;
  string         cur_req;
  bit            done;

  function automatic int route(bit second, int md, int addr);
    int off = addr % WIN;
    bit upper = (off >= HALF);
    if (!second) begin
      if (md == 3) return 3;
      if (md == 1) return 1;
      if (md == 2) return 0;
      return upper ? 1 : 0;
    end
    if (md == 0) return 2;
    if (md == 1) return 0;
    if (md == 2) return 1;
    return upper ? 1 : 0;
  endfunction

  function automatic logic [DW-1:0] rd_m(int t, int addr);
    int off = addr % WIN;
    if (t == 0) return h0_m[off % HALF];
    if (t == 1) return h1_m[off % HALF];
    if (t == 2) return pv_m[off];
    return '0;
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] be);
    logic [DW-1:0] r = old;
    for (int k = 0; k < NB; k++) if (be[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  task automatic wr_m(int t, int addr, logic [NB-1:0] be, logic [DW-1:0] d);
    int off = addr % WIN;
    if (t == 0) h0_m[off % HALF] = merge(h0_m[off % HALF], d, be);
    else if (t == 1) h1_m[off % HALF] = merge(h1_m[off % HALF], d, be);
    else if (t == 2) pv_m[off] = merge(pv_m[off], d, be);
  endtask

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_be = '0; cfg_wdata = '0;
    a_req = 0; a_we = 0; a_addr = '0; a_be = '0; a_wdata = '0;
    b_req = 0; b_we = 0; b_addr = '0; b_be = '0; b_wdata = '0;
  endtask

  task automatic set_a(logic we, int addr, logic [NB-1:0] be, logic [DW-1:0] d);
    a_req = 1; a_we = we; a_addr = AW'(addr); a_be = be; a_wdata = d;
  endtask

  task automatic set_b(logic we, int addr, logic [NB-1:0] be, logic [DW-1:0] d);
    b_req = 1; b_we = we; b_addr = AW'(addr); b_be = be; b_wdata = d;
  endtask

  task automatic set_mode(logic [NB-1:0] be, int md);
    cfg_we = 1; cfg_be = be; cfg_wdata = DW'(md) << 24;
  endtask

  // one clock: compare, advance model, clear inputs at next falling edge
  task automatic tick();
    int ta, tb;
    bit stall, bg;
    logic [DW-1:0] exp_stat;
    #1;
    ta = route(0, mode_m, int'(a_addr));
    tb = route(1, mode_m, int'(b_addr));
    stall = a_req && b_req && (ta == tb) && (ta < 2);
    bg = b_req && !stall;
    chk("a_gnt R8", DW'(a_gnt), DW'(a_req));
    chk("b_gnt R8", DW'(b_gnt), DW'(bg));
    chk("a_rvalid R7", DW'(a_rvalid), DW'(exp_arv));
    chk("b_rvalid R7", DW'(b_rvalid), DW'(exp_brv));
    if (exp_arv) chk("a_rdata", a_rdata, exp_ard);
    if (exp_brv) chk("b_rdata", b_rdata, exp_brd);
    exp_stat = DW'(mode_m) << 8;
    chk("stat R1", stat, exp_stat);
    exp_arv = a_req && !a_we;
    exp_ard = rd_m(ta, int'(a_addr));
    exp_brv = bg && !b_we;
    exp_brd = rd_m(tb, int'(b_addr));
    if (a_req && a_we && ta != 3) wr_m(ta, int'(a_addr), a_be, a_wdata);
    if (bg && b_we) wr_m(tb, int'(b_addr), b_be, b_wdata);
    if (cfg_we && cfg_be[3]) mode_m = int'(cfg_wdata[25:24]);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0; mode_m = 0;
    exp_arv = 0; exp_brv = 0; exp_ard = '0; exp_brd = '0;
    for (int i = 0; i < HALF; i++) begin h0_m[i] = '0; h1_m[i] = '0; end
    for (int i = 0; i < WIN; i++) pv_m[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1"; // reset state
    tick();

    cur_req = "R2"; // fill everything in mode 0
    for (int i = 0; i < WIN; i++) begin
      set_a(1, i, 4'hf, 32'hA000_0000 + i);
      set_b(1, i, 4'hf, 32'hB000_0000 + i);
      tick();
    end
    for (int i = 0; i < WIN; i += 37) begin
      set_a(0, i, 4'h0, '0); set_b(0, i, 4'h0, '0); tick();
    end
    tick();

    cur_req = "R6"; // mirrors across region
    for (int k = 1; k < (1 << AW) / WIN; k++) begin
      set_a(0, 5 + HALF + k * WIN, 4'h0, '0); set_b(0, 9 + k * WIN, 4'h0, '0); tick();
    end
    tick();

    cur_req = "R1"; // byte 3 disabled: no change; then load with accesses in same cycle
    set_mode(4'b0111, 3); tick(); tick();
    set_mode(4'b1000, 1);
    set_a(0, 5, 4'h0, '0); set_b(0, 5, 4'h0, '0); tick();
    set_a(0, 5, 4'h0, '0); tick(); tick();

    cur_req = "R3";
    set_a(1, 3, 4'hf, 32'h1111_0003); set_b(1, HALF + 7, 4'hf, 32'h2222_0007); tick();
    for (int i = 0; i < WIN; i += 29) begin
      set_a(0, i, 4'h0, '0); set_b(0, i + 3, 4'h0, '0); tick();
    end
    tick();

    cur_req = "R4";
    set_mode(4'b1000, 2); tick();
    for (int i = 0; i < WIN; i += 31) begin
      set_a(0, i, 4'h0, '0); set_b(0, i + 1, 4'h0, '0); tick();
    end
    tick();

    cur_req = "R9"; // A writes half 0 in mode 2, B reads it in mode 1
    set_a(1, HALF + 12, 4'hf, 32'hC0DE_000C); tick();
    set_mode(4'b1000, 1); tick();
    set_b(0, 12, 4'h0, '0); tick();
    set_b(0, HALF + 12, 4'h0, '0); tick(); tick();

    cur_req = "R5";
    set_mode(4'b1000, 3); tick();
    set_a(1, 10, 4'hf, 32'hDEAD_BEEF); tick();
    set_a(0, 10, 4'h0, '0); tick();
    set_b(1, HALF + 4, 4'hf, 32'h5555_AAAA); tick();
    set_b(0, 10, 4'h0, '0); tick();
    set_b(0, HALF + 4, 4'h0, '0); tick();
    set_mode(4'b1000, 0); tick();
    set_a(0, 10, 4'h0, '0); tick();
    set_a(0, HALF + 4, 4'h0, '0); set_b(0, 100, 4'h0, '0); tick(); tick();

    cur_req = "R7"; // byte enables, back-to-back write then read
    set_a(1, 20, 4'b0101, 32'h1234_5678); tick();
    set_a(0, 20, 4'h0, '0); tick();
    set_b(1, 30, 4'b1010, 32'h8765_4321); tick();
    set_b(0, 30, 4'h0, '0); tick(); tick();

    cur_req = "R8"; // random traffic with mode changes
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom() % 16);
      if (r == 0) set_mode(NB'($urandom()), int'($urandom() % 4));
      if ($urandom() % 4 != 0)
        set_a(1'($urandom()), int'($urandom() % (1 << AW)), NB'($urandom()), $urandom());
      if ($urandom() % 4 != 0)
        set_b(1'($urandom()), int'($urandom() % (1 << AW)), NB'($urandom()), $urandom());
      tick();
    end
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule